// File: doc/BRIEF.md
# Paged Register Map Address Decoder

This block sits behind the byte-level side of a two-wire serial slave and turns its byte accesses into reads and writes of a paged register memory. The 256-byte address space is split in two. The lower 128 bytes are one fixed page that is always visible, and it holds the time-critical data such as flags and monitor values. The upper 128 addresses are a window onto one of four upper pages. A page-select byte in the lower page chooses which upper page the window shows.

The serial engine reports the device address it received and checks `addr_hit`. It loads a byte pointer for random access and then issues byte writes or byte reads. Each access advances the pointer, so a run of accesses walks the memory in sequence. Pages 00 and 03 always exist. Pages 01 and 02 are optional and are chosen by parameters. Page 02 and page 03 are host read/write storage. Page 00 (identity data) and page 01 (application table) are read-only. The lower page has a read-only front part and a read/write tail. Read-only bytes return a fixed fill pattern that stands in for the real contents.

Top module: `paged_regmap_decoder`

## Requirements
- R1: `addr_hit` is high in the same cycle exactly when `dev_addr` equals 7'h50, which is the 8-bit bus address A0h. It is low for every other 7-bit value.
- R2: Once reset is released, the pointer is 0, `page_sel` is 0 and `rd_valid` is low.
- R3: A read (`rd_en` high, with `ptr_load` and `wr_en` both low) returns the byte at the pointer on `rd_data`, with `rd_valid` high, one cycle later. The pointer then advances by one. With no request, the pointer holds.
- R4: Each access advances the pointer by one, and 127 steps to 128. Byte 255 wraps to byte 128, not to 0, and the wrap does not change `page_sel`.
- R5: Lower-page bytes 86 to 126 are read/write storage. They read back the same value whatever `page_sel` holds.
- R6: Addresses 128 to 255 reach the page in `page_sel`. Pages 02 and 03 each keep their own 128 bytes of read/write storage.
- R7: Byte 127 is the page-select byte and reads back `page_sel`. A write of a value from 0 to 3 loads it. A write of any value of 4 or more leaves `page_sel` unchanged.
- R8: An optional page that is not implemented (page 01 by default) reads 00h at every offset, and writes to it are ignored.
- R9: Writes to read-only bytes are ignored. The read-only bytes are lower bytes 0 to 85, page 00, and page 01 when it exists. They read (code*64) XOR offset, with code 0 for the lower page, 1 for page 00 and 2 for page 01, where offset is the address minus 128 in the upper half.
- R10: A write (`wr_en` high, `ptr_load` low) stores `wr_data` at the pointer when the byte is writable, and advances the pointer by one.
- R11: `ptr_load` takes priority: when it is high, any write or read in the same cycle is dropped. When `wr_en` and `rd_en` are both high, only the write takes place and `rd_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_addr | input | 7 | Device address received by the serial engine |
| addr_hit | output | 1 | High when `dev_addr` selects this device |
| ptr_load | input | 1 | Loads the byte pointer from `ptr_val` |
| ptr_val | input | 8 | New pointer value |
| wr_en | input | 1 | Writes one byte at the pointer |
| wr_data | input | 8 | Byte to write |
| rd_en | input | 1 | Reads one byte at the pointer |
| rd_data | output | 8 | Byte read, registered |
| rd_valid | output | 1 | Pulses for one cycle when `rd_data` holds a new byte |
| page_sel | output | 2 | Upper page currently shown in the window |

## Verification
The bench targets the pointer at the edges of the window. If the design wrapped 255 to 0, or failed to carry 127 into 128, a sequential read would return a lower-page byte where an upper-page byte was expected. Every page is filled and read back through the window, then read again after page changes. A design that aliased page 02 with page 03, or let the page select reach lower storage, shows the wrong data on that second read. The bench also sends writes of out-of-range page numbers, writes to read-only bytes, and writes to the absent page. A design that accepted any of them would show a changed `page_sel` or nonzero readback. Finally, it issues load, write and read requests in the same cycle to expose a wrong priority, which would show as a stray `rd_valid` or a misplaced write.

// File: rtl/regmap_pkg.sv
package regmap_pkg;

  typedef enum logic [2:0] {
    RGN_LOWER = 3'd0,
    RGN_PG0   = 3'd1,
    RGN_PG1   = 3'd2,
    RGN_PG2   = 3'd3,
    RGN_PG3   = 3'd4
  } region_e;

  // Placeholder contents of read-only bytes: region code in the top bits, XOR offset.
  function automatic logic [7:0] fill_value(region_e rgn, logic [6:0] off);
    logic [1:0] code;
    case (rgn)
      RGN_PG0: code = 2'd1;
      RGN_PG1: code = 2'd2;
      default: code = 2'd0;
    endcase
    return {code, 6'b0} ^ {1'b0, off};
  endfunction

endpackage

// File: rtl/regmap_ptr.sv
module regmap_ptr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] WIN_BASE = AW'(1) << (AW - 1);
  localparam logic [AW-1:0] TOP_ADDR = {AW{1'b1}};

  logic [AW-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (load) begin
      ptr_d = load_val;
    end else if (step) begin
      if (ptr_q == TOP_ADDR) ptr_d = WIN_BASE;
      else                   ptr_d = ptr_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/regmap_page_sel.sv
module regmap_page_sel #(
  parameter int DW        = 8,
  parameter int NUM_PAGES = 4,
  parameter int PW        = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [PW-1:0] page
);
  localparam logic [DW-1:0] PAGE_LIMIT = DW'(NUM_PAGES);

  logic [PW-1:0] page_q, page_d;
  logic          accept;

  assign accept = wr && (wdata < PAGE_LIMIT);

  always_comb begin
    page_d = page_q;
    if (accept) page_d = wdata[PW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page_q <= '0;
    else        page_q <= page_d;
  end

  assign page = page_q;
endmodule

// File: rtl/regmap_decode.sv
module regmap_decode
  import regmap_pkg::*;
#(
  parameter int AW         = 8,
  parameter int PW         = 2,
  parameter int LOW_RO_END = 86,
  parameter int PSEL_OFF   = 127,
  parameter bit HAS_P1     = 1'b0,
  parameter bit HAS_P2     = 1'b1
) (
  input  logic [AW-1:0] ptr,
  input  logic [PW-1:0] page,
  output region_e       rgn,
  output logic [AW-2:0] off,
  output logic          is_psel,
  output logic          present,
  output logic          writable
);
  localparam int OW = AW - 1;
  localparam logic [OW-1:0] RO_END_V = OW'(LOW_RO_END);
  localparam logic [OW-1:0] PSEL_V   = OW'(PSEL_OFF);

  assign off = ptr[OW-1:0];

  always_comb begin
    if (!ptr[AW-1]) begin
      rgn = RGN_LOWER;
    end else begin
      case (page)
        2'd0:    rgn = RGN_PG0;
        2'd1:    rgn = RGN_PG1;
        2'd2:    rgn = RGN_PG2;
        default: rgn = RGN_PG3;
      endcase
    end
  end

  assign is_psel = (rgn == RGN_LOWER) && (off == PSEL_V);

  always_comb begin
    case (rgn)
      RGN_PG1: present = HAS_P1;
      RGN_PG2: present = HAS_P2;
      default: present = 1'b1;
    endcase
  end

  always_comb begin
    case (rgn)
      RGN_LOWER: writable = (off >= RO_END_V) && !is_psel;
      RGN_PG2:   writable = HAS_P2;
      RGN_PG3:   writable = 1'b1;
      default:   writable = 1'b0;
    endcase
  end
endmodule

// File: rtl/regmap_bank.sv
module regmap_bank #(
  parameter int DW    = 8,
  parameter int DEPTH = 128,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/paged_regmap_decoder.sv
module paged_regmap_decoder
  import regmap_pkg::*;
#(
  parameter int          AW         = 8,
  parameter int          DW         = 8,
  parameter int          NUM_PAGES  = 4,
  parameter int          LOW_RO_END = 86,
  parameter int          PSEL_OFF   = 127,
  parameter bit          HAS_P1     = 1'b0,
  parameter bit          HAS_P2     = 1'b1,
  parameter logic [6:0]  DEV_ADDR   = 7'h50
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [6:0]                   dev_addr,
  output logic                         addr_hit,
  input  logic                         ptr_load,
  input  logic [AW-1:0]                ptr_val,
  input  logic                         wr_en,
  input  logic [DW-1:0]                wr_data,
  input  logic                         rd_en,
  output logic [DW-1:0]                rd_data,
  output logic                         rd_valid,
  output logic [$clog2(NUM_PAGES)-1:0] page_sel
);
  localparam int PW         = $clog2(NUM_PAGES);
  localparam int OW         = AW - 1;
  localparam int PAGE_BYTES = 1 << OW;
  localparam logic [OW-1:0] RO_END_V = OW'(LOW_RO_END);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign addr_hit = (dev_addr == DEV_ADDR);

  // request qualification: load > write > read
  logic wr_fire, rd_fire, step;
  assign wr_fire = wr_en && !ptr_load;
  assign rd_fire = rd_en && !ptr_load && !wr_en;
  assign step    = wr_fire || rd_fire;

  logic [AW-1:0] ptr_q;
  regmap_ptr #(.AW(AW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (ptr_load),
    .load_val (ptr_val),
    .step     (step),
    .ptr      (ptr_q)
  );

  region_e       dec_rgn;
  logic [OW-1:0] dec_off;
  logic          dec_psel, dec_present, dec_writable;

  regmap_decode #(
    .AW(AW), .PW(PW), .LOW_RO_END(LOW_RO_END), .PSEL_OFF(PSEL_OFF),
    .HAS_P1(HAS_P1), .HAS_P2(HAS_P2)
  ) u_dec (
    .ptr      (ptr_q),
    .page     (page_sel),
    .rgn      (dec_rgn),
    .off      (dec_off),
    .is_psel  (dec_psel),
    .present  (dec_present),
    .writable (dec_writable)
  );

  regmap_page_sel #(.DW(DW), .NUM_PAGES(NUM_PAGES), .PW(PW)) u_psel (
    .clk   (clk),
    .rst_n (rst_core_n),
    .wr    (wr_fire && dec_psel),
    .wdata (wr_data),
    .page  (page_sel)
  );

  // storage banks: lower tail, page 02 (optional), page 03
  logic          we_low, we_p2, we_p3;
  logic [DW-1:0] low_rd, p2_rd, p3_rd;

  assign we_low = wr_fire && dec_writable && (dec_rgn == RGN_LOWER);
  assign we_p2  = wr_fire && dec_writable && (dec_rgn == RGN_PG2);
  assign we_p3  = wr_fire && dec_writable && (dec_rgn == RGN_PG3);

  regmap_bank #(.DW(DW), .DEPTH(PAGE_BYTES)) u_bank_low (
    .clk(clk), .we(we_low), .waddr(dec_off), .wdata(wr_data),
    .raddr(dec_off), .rdata(low_rd)
  );

  generate
    if (HAS_P2) begin : g_p2
      regmap_bank #(.DW(DW), .DEPTH(PAGE_BYTES)) u_bank_p2 (
        .clk(clk), .we(we_p2), .waddr(dec_off), .wdata(wr_data),
        .raddr(dec_off), .rdata(p2_rd)
      );
    end else begin : g_no_p2
      assign p2_rd = '0;
    end
  endgenerate

  regmap_bank #(.DW(DW), .DEPTH(PAGE_BYTES)) u_bank_p3 (
    .clk(clk), .we(we_p3), .waddr(dec_off), .wdata(wr_data),
    .raddr(dec_off), .rdata(p3_rd)
  );

  // read mux
  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (!dec_present) begin
      rd_mux = '0;
    end else begin
      case (dec_rgn)
        RGN_LOWER: begin
          if (dec_psel)                rd_mux = DW'(page_sel);
          else if (dec_off >= RO_END_V) rd_mux = low_rd;
          else                          rd_mux = fill_value(dec_rgn, dec_off);
        end
        RGN_PG2: rd_mux = p2_rd;
        RGN_PG3: rd_mux = p3_rd;
        default: rd_mux = fill_value(dec_rgn, dec_off);
      endcase
    end
  end

  logic [DW-1:0] rd_data_q, rd_data_d;
  logic          rd_valid_q;

  always_comb begin
    rd_data_d = rd_data_q;
    if (rd_fire) rd_data_d = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_data_q  <= rd_data_d;
      rd_valid_q <= rd_fire;
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;
endmodule

// File: rtl/regmap_checker.sv
module regmap_checker #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int PW = 2
) (
  input logic          clk,
  input logic          rst_core_n,
  input logic          ptr_load,
  input logic          wr_en,
  input logic          rd_en,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic [PW-1:0] page_sel,
  input logic [AW-1:0] ptr_q,
  input logic          dec_present
);
  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rd_en && !ptr_load && !wr_en) |=> rd_valid); // R3

  AST_PTR_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!ptr_load && !wr_en && !rd_en) |=> $stable(ptr_q)); // R3

  AST_WINDOW_STICKY: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ptr_q[AW-1] && !ptr_load && (wr_en || rd_en)) |=> ptr_q[AW-1]); // R4

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!wr_en || ptr_load) |=> $stable(page_sel)); // R7

  AST_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rd_en && !ptr_load && !wr_en && !dec_present) |=> (rd_data == '0)); // R8

  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(rd_en && !ptr_load && !wr_en) |=> !rd_valid); // R11
endmodule

bind paged_regmap_decoder regmap_checker #(.AW(AW), .DW(DW), .PW(PW)) u_chk (
  .clk         (clk),
  .rst_core_n  (rst_core_n),
  .ptr_load    (ptr_load),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .rd_valid    (rd_valid),
  .rd_data     (rd_data),
  .page_sel    (page_sel),
  .ptr_q       (ptr_q),
  .dec_present (dec_present)
);

// File: tb/sim_paged_regmap_decoder.sv
module sim_paged_regmap_decoder;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] dev_addr;
  logic       addr_hit;
  logic       ptr_load;
  logic [7:0] ptr_val;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       rd_en;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic [1:0] page_sel;

  always #2 clk = ~clk; // 250 MHz

  paged_regmap_decoder u0 (
    .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr), .addr_hit(addr_hit),
    .ptr_load(ptr_load), .ptr_val(ptr_val), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .page_sel(page_sel)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  // reference model
  logic [7:0] ref_low [128];
  logic [7:0] ref_p2  [128];
  logic [7:0] ref_p3  [128];
  int         ref_page;
  int         ref_ptr;

  function automatic logic [7:0] fillv(int code, int off);
    return 8'(((code * 64) ^ off) & 255);
  endfunction

  function automatic logic [7:0] exp_read(int a);
    int off;
    if (a < 128) begin
      if (a == 127) return 8'(ref_page);
      if (a < 86)   return fillv(0, a);
      return ref_low[a];
    end
    off = a - 128;
    case (ref_page)
      0:       return fillv(1, off);
      1:       return 8'h00;
      2:       return ref_p2[off];
      default: return ref_p3[off];
    endcase
  endfunction

  function automatic string tag_of(int a);
    if (a == 127)     return "R7";
    if (a < 86)       return "R9";
    if (a < 128)      return "R5";
    if (ref_page == 0) return "R9";
    if (ref_page == 1) return "R8";
    return "R6";
  endfunction

  function automatic void model_write(int a, logic [7:0] d);
    if (a == 127) begin
      if (d < 8'd4) ref_page = int'(d);
    end else if (a >= 86 && a < 128) begin
      ref_low[a] = d;
    end else if (a >= 128) begin
      if (ref_page == 2) ref_p2[a-128] = d;
      else if (ref_page == 3) ref_p3[a-128] = d;
    end
  endfunction

  function automatic int next_ptr(int a);
    return (a == 255) ? 128 : a + 1;
  endfunction

  task automatic check(string req, int actual, int expected, string what);
    n_checks++;
    if (actual != expected) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, actual, expected);
    end
  endtask

  task automatic do_load(int a);
    @(negedge clk);
    ptr_load = 1'b1; ptr_val = 8'(a);
    @(negedge clk);
    ptr_load = 1'b0;
    ref_ptr = a;
  endtask

  task automatic do_write(logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(ref_ptr, d);
    ref_ptr = next_ptr(ref_ptr);
  endtask

  task automatic do_read(string req_override);
    logic [7:0] e;
    string t;
    e = exp_read(ref_ptr);
    t = (req_override == "") ? tag_of(ref_ptr) : req_override;
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check("R3", int'(rd_valid), 1, "rd_valid after read");
    check(t, int'(rd_data), int'(e), $sformatf("read addr %0d page %0d", ref_ptr, ref_page));
    ref_ptr = next_ptr(ref_ptr);
  endtask

  initial begin
    rst_n = 1'b0; dev_addr = '0; ptr_load = 0; ptr_val = '0;
    wr_en = 0; wr_data = '0; rd_en = 0;
    ref_page = 0; ref_ptr = 0;
    for (int i = 0; i < 128; i++) begin
      ref_low[i] = 8'h00; ref_p2[i] = 8'h00; ref_p3[i] = 8'h00;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: reset state
    check("R2", int'(page_sel), 0, "page_sel after reset");
    check("R2", int'(rd_valid), 0, "rd_valid after reset");
    do_read("R2");   // pointer starts at 0
    do_read("R2");

    // R1: device address sweep
    for (int a = 0; a < 128; a++) begin
      dev_addr = 7'(a);
      #1;
      check("R1", int'(addr_hit), (a == 8'hA0 >> 1) ? 1 : 0, $sformatf("addr_hit for %0h", a));
    end

    // R10/R9/R5: write all 256 addresses from 0 (page 0 window read-only)
    do_load(0);
    for (int a = 0; a < 256; a++) do_write(8'((a * 37 + 11) & 255));
    check("R4", int'(page_sel), ref_page, "page after full sweep");
    do_load(0);
    for (int a = 0; a < 256; a++) do_read("");

    // R6/R8/R4: each page through the window, with wrap
    for (int p = 0; p < 4; p++) begin
      do_load(127);
      do_write(8'(p));
      check("R7", int'(page_sel), p, "page select write");
      for (int k = 0; k < 128; k++) do_write(8'((k * 13 + p * 71 + 5) & 255));
      check("R4", ref_ptr, 128, "model wrap");
      for (int k = 0; k < 130; k++) do_read("");
      check("R4", int'(page_sel), p, "page held across wrap");
    end

    // R6: revisit pages after switching, storage is independent
    for (int p = 3; p >= 0; p--) begin
      do_load(127);
      do_write(8'(p));
      for (int k = 0; k < 128; k++) do_read("R6");
    end

    // R5: lower page unchanged by page select
    do_load(86);
    for (int k = 86; k < 127; k++) do_read("R5");

    // R7: unsupported page numbers rejected
    do_load(127); do_write(8'd2);
    foreach (ref_low[i]) begin end
    do_load(127); do_write(8'd4);
    check("R7", int'(page_sel), 2, "page after writing 4");
    do_load(127); do_write(8'h80);
    check("R7", int'(page_sel), 2, "page after writing 80h");
    do_load(127); do_write(8'hFF);
    check("R7", int'(page_sel), 2, "page after writing FFh");
    do_load(127); do_read("R7");

    // R4: explicit crossing 127->128 and 255->128
    do_load(126);
    do_read("R4"); do_read("R4"); do_read("R4");
    do_load(255);
    do_read("R4"); do_read("R4");
    check("R4", int'(page_sel), 2, "page after 255 wrap");

    // R8: writes to absent page ignored
    do_load(127); do_write(8'd1);
    do_load(200); do_write(8'h77);
    do_load(200); do_read("R8");
    do_load(127); do_write(8'd2);
    do_load(200); do_read("R8");

    // R11: load beats read
    @(negedge clk);
    ptr_load = 1'b1; ptr_val = 8'd90; rd_en = 1'b1;
    @(negedge clk);
    ptr_load = 1'b0; rd_en = 1'b0;
    check("R11", int'(rd_valid), 0, "rd_valid with load+read");
    ref_ptr = 90;
    do_read("R11");

    // R11: write beats read
    do_load(91);
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; wr_data = 8'h5A;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R11", int'(rd_valid), 0, "rd_valid with write+read");
    model_write(91, 8'h5A);
    ref_ptr = 92;
    do_read("R11");
    do_load(91); do_read("R11");

    // R11: load beats write
    @(negedge clk);
    ptr_load = 1'b1; ptr_val = 8'd93; wr_en = 1'b1; wr_data = 8'hEE;
    @(negedge clk);
    ptr_load = 1'b0; wr_en = 1'b0;
    ref_ptr = 93;
    do_read("R11");

    // R3: idle cycles keep pointer
    do_load(100);
    repeat (5) @(negedge clk);
    do_read("R3");

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule